// File: doc/BRIEF.md
# IndustryPack Bus Cycle Controller

This block turns single requests from a local bus into bus cycles on up to four IndustryPack module slots, each with a 16-bit data path. A request names a slot, an address space, a byte address, the write data and the byte enables. The controller drives the select strobe for that space on the chosen slot and drives the write strobe, the address and the data. It then waits for the slot's acknowledge and returns the result as a one-cycle completion pulse. Only one request is in flight at a time. The request side uses a valid/ready handshake.

The block also holds a small control and status space that is reached through the same request port. Each slot has a clock-mode bit (the slow mode is the reset default), a recovery-enable bit and a software reset bit. A sticky timeout flag per slot is cleared by writing one to it. When recovery is enabled for a slot, the next cycle to that slot is held off until a programmed number of clocks has passed since the previous one ended. A slot that never acknowledges is released after a programmed window. The requester still sees a normal completion, with all-ones read data, and the event is recorded only in the status flag.

Top module: `ipbus_cycle_ctrl`

## Requirements
- R1: After reset, req_ready is high and rsp_done is low. All sixteen select outputs are high (inactive). Every slot clock-mode output is 0 (slow mode) and every slot reset output is high (not in reset).
- R2: The space code selects the strobe: 0 gives the ID strobe, 1 the IO strobe, 2 the INT strobe, and 3 or 4 the memory strobe. Only the addressed slot's strobe goes low. ip_write_n is low during write cycles, and writes to the ID and INT spaces run as real bus write cycles.
- R3: In the 16-bit spaces (codes 0 to 3), ip_addr carries the byte address shifted right by one and ip_dout carries all 16 write bits. ip_be_n carries the inverted byte enables (bit 0 is the low byte), and the slave stores only the enabled bytes.
- R4: In the 8-bit memory space (code 4), ip_addr carries the byte address unshifted and only D[7:0] is used. ip_be_n is 2'b10, write data goes out on the low byte, and read data returns as {8'h00, D[7:0]}.
- R5: After the slot acknowledges, rsp_done pulses for exactly one cycle with the read data. req_ready stays low from acceptance until the completion, so only one request is outstanding.
- R6: If no acknowledge arrives within TMO_CYC cycles of the select going low, the cycle ends and the slot's status flag is set. The request still completes normally, and a timed-out read returns 16'hFFFF.
- R7: Status flags (status register bit n = slot n) stay set until software writes 1 to that bit. Writing 0 leaves them unchanged.
- R8: With recovery enabled for a slot, at least REC_CYC cycles pass between that slot's select rising and its next select falling. With recovery disabled, the next cycle starts without that wait.
- R9: Each slot's clock-mode bit drives ip_clk32[n]. Setting a slot's software reset bit drives ip_reset_n[n] low and leaves its clock-mode bit unchanged.
- R10: Space codes 5 to 7 reach the register space and complete locally in the cycle after acceptance, with no select. addr[2:1]=0 is the control word of req_slot (bit 0 clock mode, bit 1 recovery enable). addr[2:1]=1 is status and addr[2:1]=2 is the per-slot reset mask. Other locations read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_slot | input | 2 | Target slot |
| req_space | input | 3 | Space code |
| req_addr | input | AW | Byte address |
| req_wr | input | 1 | 1 = write |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| ip_idsel_n | output | 4 | ID strobe per slot |
| ip_iosel_n | output | 4 | IO strobe per slot |
| ip_intsel_n | output | 4 | INT strobe per slot |
| ip_memsel_n | output | 4 | Memory strobe per slot |
| ip_write_n | output | 1 | Write strobe |
| ip_addr | output | AW | Slot address |
| ip_dout | output | 16 | Data to slot |
| ip_doe | output | 1 | Data output enable |
| ip_be_n | output | 2 | Byte strobes, active low |
| ip_din | input | 16 | Data from slot |
| ip_ack_n | input | 4 | Acknowledge per slot |
| ip_clk32 | output | 4 | Per-slot fast clock mode |
| ip_reset_n | output | 4 | Per-slot reset, active low |

## Verification
A wrong sequencer state shows up at the ports in one of two ways. A select can stay low past its acknowledge, or fail to fall at all. Either way the next completion pulse comes late, missing or doubled, and the bench sees it within one transaction. A corrupt timeout counter moves the select release away from exactly TMO_CYC cycles. A lost status set or a wrong recovery counter shows on the next register read, or as a wrong gap between two selects on the same slot.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUS  = 2'd2,
    ST_RESP = 2'd3
  } ipc_state_e;

  localparam logic [2:0] SP_ID    = 3'd0;
  localparam logic [2:0] SP_IO    = 3'd1;
  localparam logic [2:0] SP_INT   = 3'd2;
  localparam logic [2:0] SP_MEM16 = 3'd3;
  localparam logic [2:0] SP_MEM8  = 3'd4;

  localparam logic [1:0] CSR_CTRL  = 2'd0;
  localparam logic [1:0] CSR_STAT  = 2'd1;
  localparam logic [1:0] CSR_RESET = 2'd2;
endpackage

// File: rtl/ipc_csr.sv
module ipc_csr #(
  parameter int N_SLOT = 4,
  localparam int SW = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SW-1:0]     slot,
  input  logic [1:0]        sel,
  input  logic [15:0]       wdata,
  input  logic [N_SLOT-1:0] tmo_set,
  output logic [N_SLOT-1:0] clk32,
  output logic [N_SLOT-1:0] rec_en,
  output logic [N_SLOT-1:0] srst,
  output logic [15:0]       rdata
);
  import ipc_pkg::*;

  logic [N_SLOT-1:0] clk32_q, clk32_d;
  logic [N_SLOT-1:0] rec_q, rec_d;
  logic [N_SLOT-1:0] srst_q, srst_d;
  logic [N_SLOT-1:0] stat_q, stat_d;
  logic wr_ctrl, wr_stat, wr_rst;

  assign wr_ctrl = wr_en && (sel == CSR_CTRL);
  assign wr_stat = wr_en && (sel == CSR_STAT);
  assign wr_rst  = wr_en && (sel == CSR_RESET);

  always_comb begin
    clk32_d = clk32_q;
    rec_d   = rec_q;
    srst_d  = srst_q;
    stat_d  = stat_q;
    if (wr_ctrl) begin
      clk32_d[slot] = wdata[0];
      rec_d[slot]   = wdata[1];
    end
    if (wr_rst) srst_d = wdata[N_SLOT-1:0];
    if (wr_stat) stat_d = stat_d & ~wdata[N_SLOT-1:0];
    stat_d = stat_d | tmo_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk32_q <= '0;
      rec_q   <= '0;
      srst_q  <= '0;
      stat_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        clk32_q <= clk32_d;
        rec_q   <= rec_d;
      end
      if (wr_rst) srst_q <= srst_d;
      if (wr_stat || (tmo_set != '0)) stat_q <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      CSR_CTRL:  rdata[1:0] = {rec_q[slot], clk32_q[slot]};
      CSR_STAT:  rdata[N_SLOT-1:0] = stat_q;
      CSR_RESET: rdata[N_SLOT-1:0] = srst_q;
      default:   rdata = '0;
    endcase
  end

  assign clk32  = clk32_q;
  assign rec_en = rec_q;
  assign srst   = srst_q;

  // R7: a flag only falls after a write-one-to-clear to the status word
  a_r7_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> (($past(stat_q) & ~stat_q) == '0));

  // R9: a reset-mask write leaves the clock-mode bits alone
  a_r9_clk_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rst && !wr_ctrl) |=> (clk32_q == $past(clk32_q)));
endmodule

// File: rtl/ipc_recovery.sv
module ipc_recovery #(
  parameter int N_SLOT  = 4,
  parameter int REC_CYC = 125,
  localparam int RW = $clog2(REC_CYC + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SLOT-1:0] bus_end,
  input  logic [N_SLOT-1:0] rec_en,
  output logic [N_SLOT-1:0] rec_ok
);
  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    logic [RW-1:0] cnt_q, cnt_d;
    logic          cnt_en;

    assign cnt_en = bus_end[s] || (cnt_q != '0);

    always_comb begin
      if (bus_end[s]) cnt_d = RW'(REC_CYC);
      else            cnt_d = cnt_q - RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign rec_ok[s] = !rec_en[s] || (cnt_q == '0);

    // R8: the hold-off counter never runs above its programmed length
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RW'(REC_CYC));
  end
endmodule

// File: rtl/ipc_seq.sv
module ipc_seq #(
  parameter int N_SLOT  = 4,
  parameter int AW      = 12,
  parameter int TMO_CYC = 1000,
  localparam int SW = $clog2(N_SLOT),
  localparam int TW = $clog2(TMO_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SW-1:0]     req_slot,
  input  logic [2:0]        req_space,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_wr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic              csr_wr,
  output logic [1:0]        csr_sel,
  input  logic [15:0]       csr_rdata,
  output logic [N_SLOT-1:0] tmo_set,
  output logic [N_SLOT-1:0] bus_end,
  input  logic [N_SLOT-1:0] rec_ok,
  output logic [N_SLOT-1:0] idsel_n,
  output logic [N_SLOT-1:0] iosel_n,
  output logic [N_SLOT-1:0] intsel_n,
  output logic [N_SLOT-1:0] memsel_n,
  output logic              write_n,
  output logic [AW-1:0]     bus_addr,
  output logic [15:0]       bus_dout,
  output logic              bus_doe,
  output logic [1:0]        bus_be_n,
  input  logic [15:0]       bus_din,
  input  logic [N_SLOT-1:0] bus_ack_n
);
  import ipc_pkg::*;

  ipc_state_e    state_q, state_d;
  logic [SW-1:0] slot_q;
  logic [2:0]    space_q;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [15:0]   wdata_q;
  logic [1:0]    be_q;
  logic [15:0]   rdata_q, rdata_d;
  logic [TW-1:0] tcnt_q, tcnt_d;

  logic accept, is_csr, ack_hit, tmo_hit, in_bus, is_byte;
  logic [N_SLOT-1:0] slot_oh;
  logic [15:0] din_shaped;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign is_csr   = req_space > SP_MEM8;
  assign in_bus   = state_q == ST_BUS;
  assign ack_hit  = in_bus && !bus_ack_n[slot_q];
  assign tmo_hit  = in_bus && (tcnt_q == TW'(TMO_CYC - 1));
  assign is_byte  = space_q == SP_MEM8;
  assign slot_oh  = N_SLOT'(1) << slot_q;
  assign din_shaped = is_byte ? {8'h00, bus_din[7:0]} : bus_din;

  assign csr_wr  = accept && is_csr && req_wr;
  assign csr_sel = req_addr[2:1];

  // next state
  always_comb begin
    state_d = state_q;
    rdata_d = rdata_q;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (is_csr) begin
          state_d = ST_RESP;
          rdata_d = req_wr ? 16'h0000 : csr_rdata;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: if (rec_ok[slot_q]) state_d = ST_BUS;
      ST_BUS: begin
        if (ack_hit) begin
          state_d = ST_RESP;
          rdata_d = wr_q ? 16'h0000 : din_shaped;
        end else if (tmo_hit) begin
          state_d = ST_RESP;
          rdata_d = wr_q ? 16'h0000 : 16'hFFFF;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    tcnt_d = in_bus ? tcnt_q + TW'(1) : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      tcnt_q  <= '0;
      slot_q  <= '0;
      space_q <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      state_q <= state_d;
      rdata_q <= rdata_d;
      tcnt_q  <= tcnt_d;
      if (accept) begin
        slot_q  <= req_slot;
        space_q <= req_space;
        addr_q  <= req_addr;
        wr_q    <= req_wr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
    end
  end

  assign tmo_set = (tmo_hit && !ack_hit) ? slot_oh : '0;
  assign bus_end = (ack_hit || tmo_hit) ? slot_oh : '0;

  // bus drive
  always_comb begin
    idsel_n  = '1;
    iosel_n  = '1;
    intsel_n = '1;
    memsel_n = '1;
    if (in_bus) begin
      case (space_q)
        SP_ID:   idsel_n  = ~slot_oh;
        SP_IO:   iosel_n  = ~slot_oh;
        SP_INT:  intsel_n = ~slot_oh;
        default: memsel_n = ~slot_oh;
      endcase
    end
  end

  assign write_n   = !(in_bus && wr_q);
  assign bus_doe   = in_bus && wr_q;
  assign bus_addr  = is_byte ? addr_q : (addr_q >> 1);
  assign bus_dout  = is_byte ? {8'h00, wdata_q[7:0]} : wdata_q;
  assign bus_be_n  = is_byte ? 2'b10 : ~be_q;
  assign req_ready = state_q == ST_IDLE;
  assign rsp_done  = state_q == ST_RESP;
  assign rsp_rdata = rdata_q;

  // R2: at most one strobe of all spaces and slots is low
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{memsel_n, intsel_n, iosel_n, idsel_n}));

  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R5: nothing more is accepted while a request is in flight
  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R6: a bus cycle never outlives the timeout window
  a_r6_tmo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_bus |-> (tcnt_q < TW'(TMO_CYC)));

  // R8: a cycle only starts once the hold-off logic released its slot
  a_r8_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bus && $past(state_q) == ST_WAIT) |-> $past(rec_ok[slot_q]));
endmodule

// File: rtl/ipbus_cycle_ctrl.sv
module ipbus_cycle_ctrl #(
  parameter int AW      = 12,
  parameter int TMO_CYC = 1000,
  parameter int REC_CYC = 125,
  localparam int N_SLOT = 4,
  localparam int SW = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SW-1:0]     req_slot,
  input  logic [2:0]        req_space,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_wr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [N_SLOT-1:0] ip_idsel_n,
  output logic [N_SLOT-1:0] ip_iosel_n,
  output logic [N_SLOT-1:0] ip_intsel_n,
  output logic [N_SLOT-1:0] ip_memsel_n,
  output logic              ip_write_n,
  output logic [AW-1:0]     ip_addr,
  output logic [15:0]       ip_dout,
  output logic              ip_doe,
  output logic [1:0]        ip_be_n,
  input  logic [15:0]       ip_din,
  input  logic [N_SLOT-1:0] ip_ack_n,
  output logic [N_SLOT-1:0] ip_clk32,
  output logic [N_SLOT-1:0] ip_reset_n
);
  logic              csr_wr;
  logic [1:0]        csr_sel;
  logic [15:0]       csr_rdata;
  logic [N_SLOT-1:0] tmo_set, bus_end, rec_ok, rec_en, srst;

  ipc_seq #(.N_SLOT(N_SLOT), .AW(AW), .TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_slot(req_slot),
    .req_space(req_space), .req_addr(req_addr), .req_wr(req_wr),
    .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_rdata(csr_rdata),
    .tmo_set(tmo_set), .bus_end(bus_end), .rec_ok(rec_ok),
    .idsel_n(ip_idsel_n), .iosel_n(ip_iosel_n), .intsel_n(ip_intsel_n),
    .memsel_n(ip_memsel_n), .write_n(ip_write_n), .bus_addr(ip_addr),
    .bus_dout(ip_dout), .bus_doe(ip_doe), .bus_be_n(ip_be_n),
    .bus_din(ip_din), .bus_ack_n(ip_ack_n)
  );

  ipc_csr #(.N_SLOT(N_SLOT)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr), .slot(req_slot),
    .sel(csr_sel), .wdata(req_wdata), .tmo_set(tmo_set),
    .clk32(ip_clk32), .rec_en(rec_en), .srst(srst), .rdata(csr_rdata)
  );

  ipc_recovery #(.N_SLOT(N_SLOT), .REC_CYC(REC_CYC)) u_rec (
    .clk(clk), .rst_n(rst_n), .bus_end(bus_end), .rec_en(rec_en),
    .rec_ok(rec_ok)
  );

  assign ip_reset_n = ~srst;
endmodule

// File: tb/ipbus_cycle_ctrl_bench.sv
module ipbus_cycle_ctrl_bench;
  localparam int AW  = 12;
  localparam int TMO = 50;
  localparam int REC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_slot = '0;
  logic [2:0] req_space = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_wr = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic rsp_done;
  logic [15:0] rsp_rdata;
  logic [3:0] idsel_n, iosel_n, intsel_n, memsel_n;
  logic ip_write_n, ip_doe;
  logic [AW-1:0] ip_addr;
  logic [15:0] ip_dout;
  logic [1:0] ip_be_n;
  logic [15:0] ip_din = '0;
  logic [3:0] ip_ack_n = 4'hF;
  logic [3:0] ip_clk32, ip_reset_n;

  ipbus_cycle_ctrl #(.AW(AW), .TMO_CYC(TMO), .REC_CYC(REC)) u_ipbus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_slot(req_slot), .req_space(req_space), .req_addr(req_addr),
    .req_wr(req_wr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ip_idsel_n(idsel_n), .ip_iosel_n(iosel_n), .ip_intsel_n(intsel_n),
    .ip_memsel_n(memsel_n), .ip_write_n(ip_write_n), .ip_addr(ip_addr),
    .ip_dout(ip_dout), .ip_doe(ip_doe), .ip_be_n(ip_be_n), .ip_din(ip_din),
    .ip_ack_n(ip_ack_n), .ip_clk32(ip_clk32), .ip_reset_n(ip_reset_n)
  );

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0, n_rsp = 0, cyc = 0;
  logic [16:0] exp_q[$];
  logic [15:0] smem [3][64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected completion", 1, 0);
      else begin
        logic [16:0] it;
        it = exp_q.pop_front();
        if (it[16]) check(rsp_rdata == it[15:0], "R5 read data", rsp_rdata, it[15:0]);
      end
      n_rsp++;
    end
  end

  // slot model: slots 0..2 acknowledge, slot 3 never does
  always @(negedge clk) begin
    logic [3:0] act;
    act = ~(idsel_n & iosel_n & intsel_n & memsel_n);
    ip_ack_n = 4'hF;
    for (int s = 0; s < 3; s++) begin
      if (act[s]) begin
        if (!ip_write_n) begin
          if (!ip_be_n[0]) smem[s][ip_addr[5:0]][7:0]  = ip_dout[7:0];
          if (!ip_be_n[1]) smem[s][ip_addr[5:0]][15:8] = ip_dout[15:8];
        end
        ip_din = smem[s][ip_addr[5:0]];
        ip_ack_n[s] = 1'b0;
      end
    end
  end

  // bus observer
  logic [15:0] obs_sel, prev_sel = '0;
  logic [AW-1:0] obs_addr;
  logic [15:0] obs_dout;
  logic obs_wn;
  logic [1:0] obs_be;
  int obs_gap, obs_len, assert_cyc;
  int last_rel[4] = '{-1000, -1000, -1000, -1000};
  always @(negedge clk) begin
    logic [15:0] sv;
    sv = ~{memsel_n, intsel_n, iosel_n, idsel_n};
    if (sv != 0 && prev_sel == 0) begin
      int sl;
      sl = 0;
      for (int b = 0; b < 16; b++) if (sv[b]) sl = b % 4;
      obs_sel = sv; obs_addr = ip_addr; obs_dout = ip_dout;
      obs_wn = ip_write_n; obs_be = ip_be_n;
      obs_gap = cyc - last_rel[sl];
      assert_cyc = cyc;
    end
    if (sv == 0 && prev_sel != 0) begin
      for (int b = 0; b < 16; b++) if (prev_sel[b]) last_rel[b % 4] = cyc;
      obs_len = cyc - assert_cyc;
    end
    prev_sel = sv;
  end

  task automatic send(input logic [1:0] slot, input logic [2:0] sp,
                      input logic [AW-1:0] a, input bit wr,
                      input logic [15:0] wd, input logic [1:0] be,
                      input bit chk, input logic [15:0] exp);
    int tgt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back({chk, exp});
    tgt = n_rsp + 1;
    req_valid = 1'b1; req_slot = slot; req_space = sp; req_addr = a;
    req_wr = wr; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    wait (n_rsp >= tgt);
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 3; s++) for (int w = 0; w < 64; w++) smem[s][w] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1 && rsp_done == 1'b0, "R1 handshake idle", {req_ready, rsp_done}, 2'b10);
    check({memsel_n, intsel_n, iosel_n, idsel_n} == 16'hFFFF, "R1 strobes", {memsel_n, intsel_n, iosel_n, idsel_n}, 16'hFFFF);
    check(ip_clk32 == 4'h0 && ip_reset_n == 4'hF, "R1 slot modes", {ip_clk32, ip_reset_n}, 8'h0F);
    rst_n = 1'b1;

    // R2 R3 16-bit memory write, slot 0
    send(2'd0, 3'd3, 12'h010, 1'b1, 16'h1234, 2'b11, 1'b0, 16'h0);
    check(obs_sel == 16'h1000, "R2 memory strobe slot0", obs_sel, 16'h1000);
    check(obs_addr == 12'h008 && obs_dout == 16'h1234 && obs_wn == 1'b0,
          "R3 word address/data", {obs_addr, obs_dout}, {12'h008, 16'h1234});
    send(2'd0, 3'd3, 12'h010, 1'b0, 16'h0, 2'b11, 1'b1, 16'h1234); // R5
    // R3 high byte only
    send(2'd0, 3'd3, 12'h010, 1'b1, 16'hAB00, 2'b10, 1'b0, 16'h0);
    check(obs_be == 2'b01, "R3 byte strobes", obs_be, 2'b01);
    send(2'd0, 3'd3, 12'h010, 1'b0, 16'h0, 2'b11, 1'b1, 16'hAB34);
    // R4 8-bit memory space
    send(2'd0, 3'd4, 12'h008, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0034);
    check(obs_addr == 12'h008 && obs_be == 2'b10, "R4 byte address", {obs_addr, obs_be}, {12'h008, 2'b10});
    send(2'd0, 3'd4, 12'h009, 1'b1, 16'hCC77, 2'b11, 1'b0, 16'h0);
    check(obs_dout == 16'h0077, "R4 low lane only", obs_dout, 16'h0077);
    send(2'd0, 3'd3, 12'h012, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0077);
    // R2 other spaces
    send(2'd1, 3'd0, 12'h002, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0);
    check(obs_sel == 16'h0002, "R2 ID strobe slot1", obs_sel, 16'h0002);
    send(2'd1, 3'd1, 12'h004, 1'b1, 16'h5A5A, 2'b11, 1'b0, 16'h0);
    check(obs_sel == 16'h0020 && obs_wn == 1'b0, "R2 IO strobe slot1", obs_sel, 16'h0020);
    send(2'd2, 3'd2, 12'h000, 1'b1, 16'h00C3, 2'b11, 1'b0, 16'h0);
    check(obs_sel == 16'h0400 && obs_wn == 1'b0, "R2 INT write slot2", {obs_sel, obs_wn}, {16'h0400, 1'b0});
    send(2'd0, 3'd0, 12'h002, 1'b1, 16'h0BEE, 2'b11, 1'b0, 16'h0);
    check(obs_sel == 16'h0001 && obs_wn == 1'b0, "R2 ID write slot0", {obs_sel, obs_wn}, {16'h0001, 1'b0});
    send(2'd1, 3'd1, 12'h004, 1'b0, 16'h0, 2'b11, 1'b1, 16'h5A5A);

    // R6 timeout on slot 3
    send(2'd3, 3'd3, 12'h000, 1'b0, 16'h0, 2'b11, 1'b1, 16'hFFFF);
    check(obs_len == TMO, "R6 window length", obs_len, TMO);
    send(2'd0, 3'd5, 12'h002, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0008); // R6 R10 status
    // R7 write 0 keeps, write 1 clears
    send(2'd0, 3'd5, 12'h002, 1'b1, 16'h0000, 2'b11, 1'b0, 16'h0);
    send(2'd0, 3'd5, 12'h002, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0008);
    send(2'd0, 3'd5, 12'h002, 1'b1, 16'h0008, 2'b11, 1'b0, 16'h0);
    send(2'd0, 3'd5, 12'h002, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0000);
    send(2'd3, 3'd1, 12'h000, 1'b1, 16'h1111, 2'b11, 1'b0, 16'h0);
    send(2'd0, 3'd5, 12'h002, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0008); // R6 write timeout

    // R9 clock mode and software reset
    send(2'd1, 3'd5, 12'h000, 1'b1, 16'h0001, 2'b11, 1'b0, 16'h0);
    check(ip_clk32 == 4'b0010, "R9 clock mode", ip_clk32, 4'b0010);
    send(2'd0, 3'd5, 12'h004, 1'b1, 16'h0002, 2'b11, 1'b0, 16'h0);
    check(ip_reset_n == 4'b1101 && ip_clk32 == 4'b0010, "R9 reset keeps clock", {ip_reset_n, ip_clk32}, 8'hD2);
    send(2'd1, 3'd5, 12'h000, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0001); // R10 ctrl readback
    send(2'd0, 3'd5, 12'h004, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0002);
    send(2'd0, 3'd5, 12'h004, 1'b1, 16'h0000, 2'b11, 1'b0, 16'h0);
    check(ip_reset_n == 4'hF, "R9 reset release", ip_reset_n, 4'hF);
    send(2'd0, 3'd5, 12'h006, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0000); // R10 unused

    // R8 recovery gap
    send(2'd0, 3'd3, 12'h000, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0);
    send(2'd0, 3'd3, 12'h000, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0);
    check(obs_gap < REC, "R8 no hold-off when disabled", obs_gap, REC);
    send(2'd0, 3'd5, 12'h000, 1'b1, 16'h0002, 2'b11, 1'b0, 16'h0);
    send(2'd0, 3'd3, 12'h000, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0);
    send(2'd0, 3'd3, 12'h000, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0);
    check(obs_gap >= REC, "R8 hold-off honoured", obs_gap, REC);
    send(2'd1, 3'd3, 12'h000, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0);
    send(2'd1, 3'd3, 12'h000, 1'b0, 16'h0, 2'b11, 1'b1, 16'h0);
    check(obs_gap < REC, "R8 other slot undelayed", obs_gap, REC);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all completions seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule